// File: doc/BRIEF.md
# SMBus Slave Command Decoder

This block is the byte-level protocol engine of an SMBus slave that exposes RAM and EEPROM locations behind a single 16-bit location pointer. A bit-level layer below it handles SDA/SCL sampling and slave-address matching. That layer hands this block one-cycle events: start, stop, a matched address with its read/write bit, each received byte, and a request for a byte to transmit. The block answers every received byte with an ACK or NACK decision one cycle later. It returns read data for transmit requests, and it issues single-cycle write requests to a memory port. While that memory port is busy and a data byte is expected, it asks the bit layer to hold SCL low.

The first byte after a write address selects the transaction. A value from 0xF8 to 0xFB is the high byte of an EEPROM location, and the next byte completes the pointer. A third byte then becomes write data for that location. The value 0xFC opens a block write: a count byte follows, then that many data bytes, stored at consecutive locations from the current pointer. Any other value, followed directly by stop, makes the pointer a RAM location 0x00nn. A read transaction returns the byte at the pointer and leaves the pointer unchanged.

Top module: `smb_cmd_decoder`

## Requirements
- R1: After reset, ack_valid, mem_wr_en, tx_valid and scl_stretch are low and mem_rd_addr is 0x0000.
- R2: A write transaction whose first byte H is in 0xF8..0xFB and whose second byte is L ACKs both bytes (ack_nack = 0), issues no write, and leaves mem_rd_addr = {H, L}.
- R3: A third byte D in such a transaction is ACKed and issues exactly one write with mem_wr_addr = {H, L} and mem_wr_data = D, in the cycle after the byte event.
- R4: A first byte outside 0xF8..0xFC followed directly by stop sets mem_rd_addr = {0x00, byte}. A second byte in such a transaction is NACKed, and the pointer is then left unchanged at stop.
- R5: A transmit request in a read transaction gives, one cycle later, tx_valid = 1 and tx_data equal to mem_rd_data at the current pointer, and the pointer does not change.
- R6: First byte 0xFC followed by a count N in 1..32 ACKs both. Each of the N data bytes is ACKed and written at the pointer, and the pointer advances by one after each, with no page limit.
- R7: A block count of 0 or above 32 is NACKed, and every later byte of that transaction is NACKed with no write.
- R8: Bytes beyond the last expected data byte of an EEPROM byte write or a block write are NACKed and issue no write.
- R9: A block data byte arriving while the pointer is above 0xFBFF is NACKed with no write, and the rest of that transaction is NACKed.
- R10: scl_stretch is high exactly when mem_busy is high and the block is waiting for an EEPROM data byte or a block data byte.
- R11: A start event abandons any transaction in progress, and a send-byte command that is cut off by a repeated start does not change the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start or repeated start seen on the bus |
| ev_stop | input | 1 | Stop seen on the bus |
| ev_addr_valid | input | 1 | Own slave address matched |
| ev_addr_rd | input | 1 | R/W bit of the matched address, 1 = read |
| ev_byte_valid | input | 1 | A byte written by the master was received |
| ev_byte_data | input | 8 | The received byte |
| tx_req | input | 1 | Bit layer needs a byte to transmit |
| tx_valid | output | 1 | tx_data holds the requested byte |
| tx_data | output | 8 | Byte to transmit |
| ack_valid | output | 1 | Decision for the last received byte is ready |
| ack_nack | output | 1 | 1 = NACK, 0 = ACK |
| mem_rd_addr | output | 16 | Current location pointer, read address |
| mem_rd_data | input | 8 | Memory data at mem_rd_addr |
| mem_wr_en | output | 1 | One-cycle write request |
| mem_wr_addr | output | 16 | Write address |
| mem_wr_data | output | 8 | Write data |
| mem_busy | input | 1 | Memory cannot accept a write yet |
| scl_stretch | output | 1 | Request to hold SCL low |

## Verification
The bound checker watches, on every cycle, the invariants that do not depend on transaction history. Every write is ACKed and lands at or below 0xFBFF. A decision or transmit byte only ever follows its triggering event. Stretch is only requested while the memory is busy. The bench's scenarios are the only way to show that command values are decoded correctly and that pointers are committed or discarded correctly. They also show that block counts, page crossing, the end-of-range cutoff and trailing bytes get the right ACK pattern, because each of these depends on the order of events within a transaction.

// File: rtl/smb_cmd_pkg.sv
package smb_cmd_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] EE_HI_FIRST = 8'hF8;
    localparam logic [DATA_W-1:0] EE_HI_LAST  = 8'hFB;
    localparam logic [DATA_W-1:0] BLOCK_CMD   = 8'hFC;
    localparam logic [ADDR_W-1:0] EE_TOP      = {EE_HI_LAST, 8'hFF};

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_SEND,
        ST_EE_LO,
        ST_EE_DATA,
        ST_BLK_CNT,
        ST_BLK_DATA,
        ST_READ,
        ST_DONE,
        ST_REJECT
    } phase_e;

    typedef struct packed {
        logic              load;
        logic              inc;
        logic [ADDR_W-1:0] value;
    } ptr_ctl_t;

    typedef struct packed {
        logic valid;
        logic nack;
    } ack_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic is_ee_hi(input logic [DATA_W-1:0] b);
        return (b >= EE_HI_FIRST) && (b <= EE_HI_LAST);
    endfunction

endpackage

// File: rtl/smb_ptr_unit.sv
module smb_ptr_unit
    import smb_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ptr_ctl_t          ctl,
    output logic [ADDR_W-1:0] ptr,
    output logic              ptr_oob
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ctl.load) begin
            ptr <= ctl.value;
        end else if (ctl.inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    assign ptr_oob = (ptr > EE_TOP);

endmodule

// File: rtl/smb_tx_unit.sv
module smb_tx_unit
    import smb_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_phase,
    input  logic              tx_req,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= tx_req && rd_phase;
            if (tx_req && rd_phase) begin
                tx_data <= mem_rd_data;
            end
        end
    end

endmodule

// File: rtl/smb_cmd_fsm.sv
module smb_cmd_fsm
    import smb_cmd_pkg::*;
#(
    parameter int MAX_BLOCK = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_addr_valid,
    input  logic              ev_addr_rd,
    input  logic              ev_byte_valid,
    input  logic [DATA_W-1:0] ev_byte_data,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              ptr_oob,
    output ptr_ctl_t          ptr_ctl,
    output ack_t              ack,
    output wr_req_t           wr,
    output logic              data_phase,
    output logic              rd_phase
);

    localparam int CNT_W = $clog2(MAX_BLOCK + 1);

    phase_e            phase, phase_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [DATA_W-1:0] ee_hi, ee_hi_n;
    logic [DATA_W-1:0] ram_cmd, ram_cmd_n;
    ack_t              ack_n;
    wr_req_t           wr_n;

    always_comb begin
        phase_n   = phase;
        cnt_n     = cnt;
        ee_hi_n   = ee_hi;
        ram_cmd_n = ram_cmd;
        ack_n     = '0;
        wr_n      = '0;
        ptr_ctl   = '0;
        if (ev_start) begin
            phase_n = ST_IDLE;
        end else if (ev_stop) begin
            if (phase == ST_SEND) begin
                ptr_ctl.load  = 1'b1;
                ptr_ctl.value = {8'h00, ram_cmd};
            end
            phase_n = ST_IDLE;
        end else if (ev_addr_valid) begin
            phase_n = ev_addr_rd ? ST_READ : ST_CMD;
        end else if (ev_byte_valid) begin
            ack_n.valid = 1'b1;
            ack_n.nack  = 1'b1;
            case (phase)
                ST_CMD: begin
                    ack_n.nack = 1'b0;
                    if (is_ee_hi(ev_byte_data)) begin
                        ee_hi_n = ev_byte_data;
                        phase_n = ST_EE_LO;
                    end else if (ev_byte_data == BLOCK_CMD) begin
                        phase_n = ST_BLK_CNT;
                    end else begin
                        ram_cmd_n = ev_byte_data;
                        phase_n   = ST_SEND;
                    end
                end
                ST_EE_LO: begin
                    ack_n.nack    = 1'b0;
                    ptr_ctl.load  = 1'b1;
                    ptr_ctl.value = {ee_hi, ev_byte_data};
                    phase_n       = ST_EE_DATA;
                end
                ST_EE_DATA: begin
                    ack_n.nack = 1'b0;
                    wr_n.en    = 1'b1;
                    wr_n.addr  = ptr;
                    wr_n.data  = ev_byte_data;
                    phase_n    = ST_DONE;
                end
                ST_BLK_CNT: begin
                    if (ev_byte_data == '0 || ev_byte_data > DATA_W'(MAX_BLOCK)) begin
                        phase_n = ST_REJECT;
                    end else begin
                        ack_n.nack = 1'b0;
                        cnt_n      = CNT_W'(ev_byte_data);
                        phase_n    = ST_BLK_DATA;
                    end
                end
                ST_BLK_DATA: begin
                    if (ptr_oob) begin
                        phase_n = ST_REJECT;
                    end else begin
                        ack_n.nack  = 1'b0;
                        wr_n.en     = 1'b1;
                        wr_n.addr   = ptr;
                        wr_n.data   = ev_byte_data;
                        ptr_ctl.inc = 1'b1;
                        cnt_n       = cnt - 1'b1;
                        if (cnt == CNT_W'(1)) begin
                            phase_n = ST_DONE;
                        end
                    end
                end
                ST_SEND: phase_n = ST_REJECT;
                default: phase_n = phase;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= ST_IDLE;
            cnt     <= '0;
            ee_hi   <= '0;
            ram_cmd <= '0;
            ack     <= '0;
            wr      <= '0;
        end else begin
            phase   <= phase_n;
            cnt     <= cnt_n;
            ee_hi   <= ee_hi_n;
            ram_cmd <= ram_cmd_n;
            ack     <= ack_n;
            wr      <= wr_n;
        end
    end

    assign data_phase = (phase == ST_EE_DATA) || (phase == ST_BLK_DATA);
    assign rd_phase   = (phase == ST_READ);

endmodule

// File: rtl/smb_cmd_decoder.sv
module smb_cmd_decoder
    import smb_cmd_pkg::*;
#(
    parameter int MAX_BLOCK = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_addr_valid,
    input  logic              ev_addr_rd,
    input  logic              ev_byte_valid,
    input  logic [DATA_W-1:0] ev_byte_data,
    input  logic              tx_req,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              ack_valid,
    output logic              ack_nack,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_busy,
    output logic              scl_stretch
);

    ptr_ctl_t          ptr_ctl;
    ack_t              ack;
    wr_req_t           wr;
    logic [ADDR_W-1:0] ptr;
    logic              ptr_oob;
    logic              data_phase;
    logic              rd_phase;

    smb_cmd_fsm #(.MAX_BLOCK(MAX_BLOCK)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .ev_start      (ev_start),
        .ev_stop       (ev_stop),
        .ev_addr_valid (ev_addr_valid),
        .ev_addr_rd    (ev_addr_rd),
        .ev_byte_valid (ev_byte_valid),
        .ev_byte_data  (ev_byte_data),
        .ptr           (ptr),
        .ptr_oob       (ptr_oob),
        .ptr_ctl       (ptr_ctl),
        .ack           (ack),
        .wr            (wr),
        .data_phase    (data_phase),
        .rd_phase      (rd_phase)
    );

    smb_ptr_unit u_ptr (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ptr_ctl),
        .ptr     (ptr),
        .ptr_oob (ptr_oob)
    );

    smb_tx_unit u_tx (
        .clk         (clk),
        .rst         (rst),
        .rd_phase    (rd_phase),
        .tx_req      (tx_req),
        .mem_rd_data (mem_rd_data),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data)
    );

    assign ack_valid   = ack.valid;
    assign ack_nack    = ack.nack;
    assign mem_wr_en   = wr.en;
    assign mem_wr_addr = wr.addr;
    assign mem_wr_data = wr.data;
    assign mem_rd_addr = ptr;
    assign scl_stretch = mem_busy && data_phase;

endmodule

// File: rtl/smb_cmd_decoder_chk.sv
module smb_cmd_decoder_chk
    import smb_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ev_byte_valid,
    input logic              tx_req,
    input logic              tx_valid,
    input logic              ack_valid,
    input logic              ack_nack,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              mem_busy,
    input logic              scl_stretch
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ack_valid && !mem_wr_en && !tx_valid));

    // R6
    ack_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(ev_byte_valid));

    // R8
    write_is_acked_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (ack_valid && !ack_nack));

    // R9
    write_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_wr_addr <= EE_TOP));

    // R5
    tx_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(tx_req));

    // R10
    stretch_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        scl_stretch |-> mem_busy);

endmodule

bind smb_cmd_decoder smb_cmd_decoder_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ev_byte_valid (ev_byte_valid),
    .tx_req        (tx_req),
    .tx_valid      (tx_valid),
    .ack_valid     (ack_valid),
    .ack_nack      (ack_nack),
    .mem_wr_en     (mem_wr_en),
    .mem_wr_addr   (mem_wr_addr),
    .mem_busy      (mem_busy),
    .scl_stretch   (scl_stretch)
);

// File: tb/sim_smb_cmd_decoder.sv
module sim_smb_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_start = 0, ev_stop = 0, ev_addr_valid = 0, ev_addr_rd = 0;
    logic        ev_byte_valid = 0;
    logic [7:0]  ev_byte_data = '0;
    logic        tx_req = 0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        ack_valid, ack_nack;
    logic [15:0] mem_rd_addr;
    logic [7:0]  mem_rd_data;
    logic        mem_wr_en;
    logic [15:0] mem_wr_addr;
    logic [7:0]  mem_wr_data;
    logic        mem_busy = 0;
    logic        scl_stretch;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    function automatic logic [7:0] mem_model(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'h5A;
    endfunction

    assign mem_rd_data = mem_model(mem_rd_addr);

    smb_cmd_decoder u0 (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_addr_valid(ev_addr_valid), .ev_addr_rd(ev_addr_rd),
        .ev_byte_valid(ev_byte_valid), .ev_byte_data(ev_byte_data),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data),
        .ack_valid(ack_valid), .ack_nack(ack_nack),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_busy(mem_busy), .scl_stretch(scl_stretch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic start_ev();
        @(negedge clk); ev_start = 1;
        @(negedge clk); ev_start = 0;
    endtask

    task automatic stop_ev();
        @(negedge clk); ev_stop = 1;
        @(negedge clk); ev_stop = 0;
    endtask

    task automatic addr_ev(input logic rd);
        @(negedge clk); ev_addr_valid = 1; ev_addr_rd = rd;
        @(negedge clk); ev_addr_valid = 0; ev_addr_rd = 0;
    endtask

    // send a byte, then check the decision and any write it caused
    task automatic byte_ev(input logic [7:0] b, input logic exp_nack,
                           input logic exp_wr, input logic [15:0] exp_addr,
                           input string req);
        @(negedge clk); ev_byte_valid = 1; ev_byte_data = b;
        @(negedge clk); ev_byte_valid = 0;
        chk(req, "ack_valid", 32'(ack_valid), 32'd1);
        chk(req, "ack_nack", 32'(ack_nack), 32'(exp_nack));
        chk(req, "mem_wr_en", 32'(mem_wr_en), 32'(exp_wr));
        if (exp_wr) begin
            chk(req, "mem_wr_addr", 32'(mem_wr_addr), 32'(exp_addr));
            chk(req, "mem_wr_data", 32'(mem_wr_data), 32'(b));
        end
    endtask

    task automatic set_ee_ptr(input logic [15:0] p);
        start_ev(); addr_ev(1'b0);
        byte_ev(p[15:8], 1'b0, 1'b0, 16'h0, "R2");
        byte_ev(p[7:0],  1'b0, 1'b0, 16'h0, "R2");
        stop_ev();
    endtask

    task automatic t_reset();
        chk("R1", "ack_valid", 32'(ack_valid), 0);
        chk("R1", "mem_wr_en", 32'(mem_wr_en), 0);
        chk("R1", "tx_valid", 32'(tx_valid), 0);
        chk("R1", "scl_stretch", 32'(scl_stretch), 0);
        chk("R1", "mem_rd_addr", 32'(mem_rd_addr), 0);
    endtask

    task automatic t_ee_pointer();
        set_ee_ptr(16'hF934);
        chk("R2", "pointer", 32'(mem_rd_addr), 32'hF934);
    endtask

    task automatic read_byte(input logic [15:0] exp_ptr, input string req);
        start_ev(); addr_ev(1'b1);
        @(negedge clk); tx_req = 1;
        @(negedge clk); tx_req = 0;
        chk(req, "tx_valid", 32'(tx_valid), 1);
        chk(req, "tx_data", 32'(tx_data), 32'(mem_model(exp_ptr)));
        stop_ev();
        chk(req, "pointer after read", 32'(mem_rd_addr), 32'(exp_ptr));
    endtask

    task automatic t_ee_write();
        start_ev(); addr_ev(1'b0);
        byte_ev(8'hFA, 1'b0, 1'b0, 16'h0, "R3");
        byte_ev(8'h10, 1'b0, 1'b0, 16'h0, "R3");
        byte_ev(8'hAB, 1'b0, 1'b1, 16'hFA10, "R3");
        byte_ev(8'hCD, 1'b1, 1'b0, 16'h0, "R8");
        stop_ev();
        chk("R3", "pointer", 32'(mem_rd_addr), 32'hFA10);
    endtask

    task automatic t_send_byte();
        start_ev(); addr_ev(1'b0);
        byte_ev(8'h42, 1'b0, 1'b0, 16'h0, "R4");
        stop_ev();
        chk("R4", "ram pointer", 32'(mem_rd_addr), 32'h0042);
        read_byte(16'h0042, "R5");
        start_ev(); addr_ev(1'b0);
        byte_ev(8'h55, 1'b0, 1'b0, 16'h0, "R4");
        byte_ev(8'h11, 1'b1, 1'b0, 16'h0, "R4");
        stop_ev();
        chk("R4", "pointer kept", 32'(mem_rd_addr), 32'h0042);
    endtask

    task automatic t_restart();
        start_ev(); addr_ev(1'b0);
        byte_ev(8'h66, 1'b0, 1'b0, 16'h0, "R11");
        start_ev();
        stop_ev();
        chk("R11", "pointer after restart", 32'(mem_rd_addr), 32'h0042);
    endtask

    task automatic t_block_page();
        set_ee_ptr(16'hF81E);
        start_ev(); addr_ev(1'b0);
        byte_ev(8'hFC, 1'b0, 1'b0, 16'h0, "R6");
        byte_ev(8'd4,  1'b0, 1'b0, 16'h0, "R6");
        for (int i = 0; i < 4; i++) begin
            byte_ev(8'(8'hA0 + i), 1'b0, 1'b1, 16'(16'hF81E + i), "R6");
        end
        chk("R6", "pointer advanced", 32'(mem_rd_addr), 32'hF822);
        byte_ev(8'h77, 1'b1, 1'b0, 16'h0, "R8");
        stop_ev();
    endtask

    task automatic t_bad_count();
        start_ev(); addr_ev(1'b0);
        byte_ev(8'hFC, 1'b0, 1'b0, 16'h0, "R7");
        byte_ev(8'd0,  1'b1, 1'b0, 16'h0, "R7");
        byte_ev(8'h12, 1'b1, 1'b0, 16'h0, "R7");
        stop_ev();
        start_ev(); addr_ev(1'b0);
        byte_ev(8'hFC, 1'b0, 1'b0, 16'h0, "R7");
        byte_ev(8'd33, 1'b1, 1'b0, 16'h0, "R7");
        byte_ev(8'h34, 1'b1, 1'b0, 16'h0, "R7");
        stop_ev();
        start_ev(); addr_ev(1'b0);
        byte_ev(8'hFC, 1'b0, 1'b0, 16'h0, "R6");
        byte_ev(8'd32, 1'b0, 1'b0, 16'h0, "R6");
        stop_ev();
    endtask

    task automatic t_range_end();
        set_ee_ptr(16'hFBFE);
        start_ev(); addr_ev(1'b0);
        byte_ev(8'hFC, 1'b0, 1'b0, 16'h0, "R9");
        byte_ev(8'd4,  1'b0, 1'b0, 16'h0, "R9");
        byte_ev(8'h01, 1'b0, 1'b1, 16'hFBFE, "R9");
        byte_ev(8'h02, 1'b0, 1'b1, 16'hFBFF, "R9");
        byte_ev(8'h03, 1'b1, 1'b0, 16'h0, "R9");
        byte_ev(8'h04, 1'b1, 1'b0, 16'h0, "R9");
        stop_ev();
    endtask

    task automatic t_stretch();
        @(negedge clk); mem_busy = 1;
        @(negedge clk);
        chk("R10", "stretch while idle", 32'(scl_stretch), 0);
        mem_busy = 0;
        set_ee_ptr(16'hF900);
        start_ev(); addr_ev(1'b0);
        byte_ev(8'hFC, 1'b0, 1'b0, 16'h0, "R10");
        mem_busy = 1;
        @(negedge clk);
        chk("R10", "stretch in count phase", 32'(scl_stretch), 0);
        mem_busy = 0;
        byte_ev(8'd1, 1'b0, 1'b0, 16'h0, "R10");
        chk("R10", "no stretch when free", 32'(scl_stretch), 0);
        mem_busy = 1;
        @(negedge clk);
        chk("R10", "stretch while busy", 32'(scl_stretch), 1);
        mem_busy = 0;
        @(negedge clk);
        byte_ev(8'h5E, 1'b0, 1'b1, 16'hF900, "R10");
        mem_busy = 1;
        @(negedge clk);
        chk("R10", "stretch after last byte", 32'(scl_stretch), 0);
        mem_busy = 0;
        stop_ev();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_ee_pointer();
        read_byte(16'hF934, "R5");
        t_ee_write();
        t_send_byte();
        t_restart();
        t_block_page();
        t_bad_count();
        t_range_end();
        t_stretch();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule